// File: doc/BRIEF.md
# MMC SPI-Mode Command Sequencer

This block runs one complete command transaction without a data phase against a MultiMediaCard in SPI mode. A host register interface supplies a command index, a 32-bit argument, a 7-bit CRC, a clock divider and a busy-wait limit. A one-cycle `start` pulse selects the card by pulling chip select low. The block then shifts out a 48-bit command frame and clocks fill bytes until the card answers. It releases chip select and then polls the card's data-busy indication, which follows write and erase commands.

The serial port uses clock polarity 0 and phase 0. Data leaves on the transmit line while the serial clock is low. The receive line is sampled on the rising clock edge. Progress is reported through two status flags and five sticky event flags, each cleared by writing one. The block has no streaming data path: command fields are plain levels that are held during a transaction, and flags are plain outputs. No valid/ready handshake applies.

Top module: `mmc_spi_cmd_seq`

## Requirements
- R1: `cs_n` idles high. A `start` pulse sampled while neither `seq_busy` nor `data_busy` is set drives `cs_n` low and sets `seq_busy` at that same clock edge.
- R2: `sclk` idles low. Each bit holds `sclk` low for `clk_div`+1 cycles and then high for `clk_div`+1 cycles. `miso` is sampled at the low-to-high transition, and `mosi` changes only while `sclk` is low.
- R3: The command frame goes out MSB first as six bytes: 0, 1, `cmd_index`[5:0], `cmd_arg`[31:0], `cmd_crc`[6:0], 1. `mosi` idles at 1, including the two idle cycles between bytes. During response and busy polling, fill bytes of 0xFF are sent.
- R4: Flag bit 0 (command sent) sets one cycle after the last frame bit's falling clock edge.
- R5: The response is the first received byte after the frame whose bit 7 is 0, and it appears on `resp_byte` (reset value 0xFF). In the same cycle `cs_n` rises, `seq_busy` clears, and flag bit 1 (sequence end) sets.
- R6: If eight response bytes all have bit 7 set, flag bits 3 (response timeout) and 1 set, `cs_n` rises, `seq_busy` clears, `resp_byte` keeps its old value, and no busy polling follows. A response in the eighth byte still counts as a response.
- R7: After a response, `data_busy` sets and the block keeps clocking 0xFF bytes with `cs_n` high. The first received byte equal to 0xFF clears `data_busy` and sets flag bit 2 (busy end). `seq_busy` and `data_busy` are never both set.
- R8: If `busy_limit` polled bytes pass without a 0xFF byte, `data_busy` clears and flag bit 4 (busy-wait error) sets, not bit 2. A limit of 0 behaves as 1.
- R9: A `start` pulse is ignored while `seq_busy` or `data_busy` is set.
- R10: Flags stay set until a `irq_clr` pulse with a 1 in the matching bit position clears them. Bits written 0 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a transaction |
| cmd_index | input | 6 | Command index field |
| cmd_arg | input | 32 | Command argument field |
| cmd_crc | input | 7 | CRC field supplied by the host |
| clk_div | input | 8 | Half-period of `sclk` minus one, in clock cycles |
| busy_limit | input | 8 | Maximum number of polled busy bytes |
| irq_clr | input | 5 | Write-one-to-clear pulse for the flags |
| miso | input | 1 | Receive line from the card |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Transmit line to the card |
| seq_busy | output | 1 | Command sequence in progress |
| data_busy | output | 1 | Card busy phase being polled |
| resp_byte | output | 8 | Last captured response byte |
| irq_flags | output | 5 | Sticky flags: 0 sent, 1 sequence end, 2 busy end, 3 timeout, 4 busy error |

## Verification
The assertions assume that `start` and `irq_clr` are single-cycle pulses, and that the command fields, `clk_div` and `busy_limit` stay unchanged while `seq_busy` or `data_busy` is set. The stimulus changes configuration only after both flags read low. It asserts `irq_clr` only between transactions, and applies extra `start` pulses only inside a command or a busy phase, where they must be ignored. The card model changes `miso` on the falling clock edge and presents fill, response and busy bytes from a per-test list, so every sample the block takes is stable.

// File: rtl/mmc_seq_pkg.sv
package mmc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_RESP = 2'd2,
    ST_POLL = 2'd3
  } seq_state_t;

  localparam int IRQ_W        = 5;
  localparam int IRQ_SENT     = 0;
  localparam int IRQ_SEQ_END  = 1;
  localparam int IRQ_BUSY_END = 2;
  localparam int IRQ_TIMEOUT  = 3;
  localparam int IRQ_BUSY_ERR = 4;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DIV_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic [DIV_W-1:0]  div,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int BIT_CW = $clog2(BYTE_W);

  logic              active_q, half_q, done_q;
  logic [DIV_W-1:0]  div_q;
  logic [BIT_CW-1:0] bit_q;
  logic [BYTE_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      half_q   <= 1'b0;
      done_q   <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      tx_q     <= '1;
      rx_q     <= '1;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (go) begin
          active_q <= 1'b1;
          half_q   <= 1'b0;
          div_q    <= '0;
          bit_q    <= '0;
          tx_q     <= tx_byte;
        end
      end else if (div_q == div) begin
        div_q <= '0;
        if (!half_q) begin
          half_q <= 1'b1;
          rx_q   <= {rx_q[BYTE_W-2:0], miso};
        end else begin
          half_q <= 1'b0;
          tx_q   <= {tx_q[BYTE_W-2:0], 1'b1};
          if (bit_q == BIT_CW'(BYTE_W-1)) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign sclk    = active_q & half_q;
  assign mosi    = active_q ? tx_q[BYTE_W-1] : 1'b1;
  assign done    = done_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/mmc_irq_flags.sv
module mmc_irq_flags #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_ev,
  input  logic [W-1:0] clr_ev,
  output logic [W-1:0] flags
);
  logic [W-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_ev) | set_ev;
  end

  assign flags = flags_q;
endmodule

// File: rtl/mmc_seq_ctrl.sv
module mmc_seq_ctrl
  import mmc_seq_pkg::*;
#(
  parameter int IDX_W       = 6,
  parameter int ARG_W       = 32,
  parameter int CRC_W       = 7,
  parameter int LIM_W       = 8,
  parameter int RESP_TRIES  = 8,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic [CRC_W-1:0]  cmd_crc,
  input  logic [LIM_W-1:0]  busy_limit,
  input  logic              done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              go,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              cs_n,
  output logic              seq_busy,
  output logic              data_busy,
  output logic [BYTE_W-1:0] resp_byte,
  output logic [IRQ_W-1:0]  irq_set
);
  localparam int FRAME_W     = 3 + IDX_W + ARG_W + CRC_W;
  localparam int FRAME_BYTES = FRAME_W / BYTE_W;
  localparam int CNT_MAX     = (RESP_TRIES > FRAME_BYTES) ? RESP_TRIES : FRAME_BYTES;
  localparam int CNT_W       = $clog2(CNT_MAX + 1);

  seq_state_t          state_q;
  logic [FRAME_W-1:0]  frame_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [LIM_W-1:0]    pcnt_q;
  logic                go_q, cs_n_q, busy_q, dt_q;
  logic [BYTE_W-1:0]   resp_q;
  logic                cmd_last, resp_hit, resp_to, poll_ok, poll_err;

  always_comb begin
    cmd_last = (state_q == ST_CMD)  && done && (cnt_q == CNT_W'(FRAME_BYTES - 1));
    resp_hit = (state_q == ST_RESP) && done && !rx_byte[BYTE_W-1];
    resp_to  = (state_q == ST_RESP) && done && rx_byte[BYTE_W-1]
               && (cnt_q == CNT_W'(RESP_TRIES - 1));
    poll_ok  = (state_q == ST_POLL) && done && (rx_byte == '1);
    poll_err = (state_q == ST_POLL) && done && (rx_byte != '1)
               && (({1'b0, pcnt_q} + 1'b1) >= {1'b0, busy_limit});
    irq_set               = '0;
    irq_set[IRQ_SENT]     = cmd_last;
    irq_set[IRQ_SEQ_END]  = resp_hit | resp_to;
    irq_set[IRQ_BUSY_END] = poll_ok;
    irq_set[IRQ_TIMEOUT]  = resp_to;
    irq_set[IRQ_BUSY_ERR] = poll_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      frame_q <= '1;
      cnt_q   <= '0;
      pcnt_q  <= '0;
      go_q    <= 1'b0;
      cs_n_q  <= 1'b1;
      busy_q  <= 1'b0;
      dt_q    <= 1'b0;
      resp_q  <= '1;
    end else begin
      go_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          frame_q <= {2'b01, cmd_index, cmd_arg, cmd_crc, 1'b1};
          cnt_q   <= '0;
          cs_n_q  <= 1'b0;
          busy_q  <= 1'b1;
          go_q    <= 1'b1;
          state_q <= ST_CMD;
        end
        ST_CMD: if (done) begin
          go_q <= 1'b1;
          if (cmd_last) begin
            cnt_q   <= '0;
            state_q <= ST_RESP;
          end else begin
            frame_q <= frame_q << BYTE_W;
            cnt_q   <= cnt_q + 1'b1;
          end
        end
        ST_RESP: if (done) begin
          if (resp_hit) begin
            resp_q  <= rx_byte;
            cs_n_q  <= 1'b1;
            busy_q  <= 1'b0;
            dt_q    <= 1'b1;
            pcnt_q  <= '0;
            go_q    <= 1'b1;
            state_q <= ST_POLL;
          end else if (resp_to) begin
            cs_n_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            go_q  <= 1'b1;
          end
        end
        ST_POLL: if (done) begin
          if (poll_ok || poll_err) begin
            dt_q    <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
            go_q   <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign go        = go_q;
  assign tx_byte   = (state_q == ST_CMD) ? frame_q[FRAME_W-1 -: BYTE_W] : '1;
  assign cs_n      = cs_n_q;
  assign seq_busy  = busy_q;
  assign data_busy = dt_q;
  assign resp_byte = resp_q;
endmodule

// File: rtl/mmc_spi_cmd_seq.sv
module mmc_spi_cmd_seq
  import mmc_seq_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int ARG_W      = 32,
  parameter int CRC_W      = 7,
  parameter int DIV_W      = 8,
  parameter int LIM_W      = 8,
  parameter int RESP_TRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] cmd_index,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic [CRC_W-1:0] cmd_crc,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [LIM_W-1:0] busy_limit,
  input  logic [IRQ_W-1:0] irq_clr,
  input  logic             miso,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  output logic             seq_busy,
  output logic             data_busy,
  output logic [7:0]       resp_byte,
  output logic [IRQ_W-1:0] irq_flags
);
  localparam int BYTE_W = 8;

  logic              go, done;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic [IRQ_W-1:0]  irq_set;

  mmc_seq_ctrl #(
    .IDX_W(IDX_W), .ARG_W(ARG_W), .CRC_W(CRC_W), .LIM_W(LIM_W),
    .RESP_TRIES(RESP_TRIES), .BYTE_W(BYTE_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_crc(cmd_crc),
    .busy_limit(busy_limit), .done(done), .rx_byte(rx_byte),
    .go(go), .tx_byte(tx_byte), .cs_n(cs_n), .seq_busy(seq_busy),
    .data_busy(data_busy), .resp_byte(resp_byte), .irq_set(irq_set)
  );

  spi_byte_shifter #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(go), .tx_byte(tx_byte), .div(clk_div),
    .miso(miso), .sclk(sclk), .mosi(mosi), .done(done), .rx_byte(rx_byte)
  );

  mmc_irq_flags #(.W(IRQ_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_ev(irq_set), .clr_ev(irq_clr),
    .flags(irq_flags)
  );
endmodule

// File: rtl/mmc_seq_checker.sv
module mmc_seq_checker #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         sclk,
  input logic         mosi,
  input logic         cs_n,
  input logic         seq_busy,
  input logic         data_busy,
  input logic [W-1:0] irq_clr,
  input logic [W-1:0] irq_flags
);
  AST_START_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    start && !seq_busy && !data_busy |=> !cs_n && seq_busy); // R1

  AST_SCLK_IN_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> (seq_busy || data_busy)); // R2

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk && $past(sclk) |-> $stable(mosi)); // R2

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> cs_n); // R5

  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_busy && data_busy)); // R7

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    start && data_busy |=> cs_n); // R9

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(irq_flags) & ~$past(irq_clr)) & ~irq_flags) == '0); // R10
endmodule

bind mmc_spi_cmd_seq mmc_seq_checker #(.W(mmc_seq_pkg::IRQ_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sclk(sclk), .mosi(mosi),
  .cs_n(cs_n), .seq_busy(seq_busy), .data_busy(data_busy),
  .irq_clr(irq_clr), .irq_flags(irq_flags)
);

// File: tb/test_mmc_spi_cmd_seq.sv
module test_mmc_spi_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start = 1'b0;
  logic [5:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic [6:0]  cmd_crc = '0;
  logic [7:0]  clk_div = 8'd1;
  logic [7:0]  busy_limit = 8'd16;
  logic [4:0]  irq_clr = '0;
  logic        miso = 1'b1;
  logic        sclk, cs_n, mosi, seq_busy, data_busy;
  logic [7:0]  resp_byte;
  logic [4:0]  irq_flags;

  mmc_spi_cmd_seq i_mmc_spi_cmd_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .cmd_crc(cmd_crc), .clk_div(clk_div),
    .busy_limit(busy_limit), .irq_clr(irq_clr), .miso(miso), .sclk(sclk),
    .cs_n(cs_n), .mosi(mosi), .seq_busy(seq_busy), .data_busy(data_busy),
    .resp_byte(resp_byte), .irq_flags(irq_flags)
  );

  always #4 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  string phase_tag = "-";

  logic       exp_sclk = 1'b0, exp_cs = 1'b1, exp_mosi = 1'b1;
  logic       exp_busy = 1'b0, exp_dt = 1'b0;
  logic [7:0] exp_resp = 8'hFF;
  logic [4:0] exp_flags = '0;

  logic [7:0] card_q[$];

  function automatic logic [7:0] card_byte(int k);
    if (k < 6) return 8'hFF;
    if (k - 6 < card_q.size()) return card_q[k - 6];
    return 8'hFF;
  endfunction

  // Card model: changes its line after each falling serial clock edge
  int   card_k = 0, card_bit = 0;
  logic cs_prev = 1'b1, sclk_prev = 1'b0;
  always @(negedge clk) begin
    logic [7:0] cur;
    if (cs_prev && !cs_n) begin
      card_k = 0;
      card_bit = 0;
    end else if (sclk_prev && !sclk) begin
      if (card_bit == 7) begin card_bit = 0; card_k++; end
      else card_bit++;
    end
    cs_prev = cs_n;
    sclk_prev = sclk;
    cur = card_byte(card_k);
    miso = cur[7 - card_bit];
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s [%s] act=%0h exp=%0h at %0t", what, phase_tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk({7'b0, sclk}, {7'b0, exp_sclk}, "R2 sclk");
    chk({7'b0, mosi}, {7'b0, exp_mosi}, "R3 mosi");
    chk({7'b0, cs_n}, {7'b0, exp_cs}, "R1 cs_n");
    chk({7'b0, seq_busy}, {7'b0, exp_busy}, "R5 seq_busy");
    chk({7'b0, data_busy}, {7'b0, exp_dt}, "R7 data_busy");
    chk(resp_byte, exp_resp, "R5 resp_byte");
    chk({7'b0, irq_flags[0]}, {7'b0, exp_flags[0]}, "R4 flag sent");
    chk({7'b0, irq_flags[1]}, {7'b0, exp_flags[1]}, "R5 flag seq_end");
    chk({7'b0, irq_flags[2]}, {7'b0, exp_flags[2]}, "R7 flag busy_end");
    chk({7'b0, irq_flags[3]}, {7'b0, exp_flags[3]}, "R6 flag timeout");
    chk({7'b0, irq_flags[4]}, {7'b0, exp_flags[4]}, "R8 flag busy_err");
  end

  // Reference: one byte of serial timing, starting at the edge the shifter loads
  task automatic model_byte(input logic [7:0] tx);
    for (int i = 7; i >= 0; i--) begin
      @(posedge clk); exp_sclk = 1'b0; exp_mosi = tx[i];
      repeat (int'(clk_div)) @(posedge clk);
      @(posedge clk); exp_sclk = 1'b1;
      repeat (int'(clk_div)) @(posedge clk);
    end
    @(posedge clk); exp_sclk = 1'b0; exp_mosi = 1'b1;
  endtask

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [6:0] crc);
    logic [47:0] frame;
    logic [7:0]  v;
    int          k;
    bit          got, fin;
    int          n;
    frame = {1'b0, 1'b1, idx, arg, crc, 1'b1};
    cmd_index = idx; cmd_arg = arg; cmd_crc = crc;
    @(negedge clk); start = 1'b1;
    @(posedge clk); exp_cs = 1'b0; exp_busy = 1'b1;  // R1
    @(negedge clk); start = 1'b0;
    for (int b = 0; b < 6; b++) begin
      model_byte(frame[47 - 8*b -: 8]);
      @(posedge clk);
      if (b == 5) exp_flags[0] = 1'b1;                // R4
    end
    k = 6; got = 1'b0;
    for (int r = 0; r < 8 && !got; r++) begin
      model_byte(8'hFF);
      v = card_byte(k); k++;
      @(posedge clk);
      if (!v[7]) begin
        got = 1'b1; exp_resp = v; exp_cs = 1'b1; exp_busy = 1'b0;
        exp_flags[1] = 1'b1; exp_dt = 1'b1;           // R5, R7
      end else if (r == 7) begin
        exp_flags[3] = 1'b1; exp_flags[1] = 1'b1;     // R6
        exp_cs = 1'b1; exp_busy = 1'b0;
      end
    end
    if (got) begin
      n = 0; fin = 1'b0;
      while (!fin) begin
        model_byte(8'hFF);
        v = card_byte(k); k++;
        @(posedge clk);
        if (v == 8'hFF) begin
          exp_dt = 1'b0; exp_flags[2] = 1'b1; fin = 1'b1;   // R7
        end else if (n + 1 >= int'(busy_limit)) begin
          exp_dt = 1'b0; exp_flags[4] = 1'b1; fin = 1'b1;   // R8
        end else n++;
      end
    end
  endtask

  task automatic clear_flags(input logic [4:0] mask);
    phase_tag = "R10";
    @(negedge clk); irq_clr = mask;
    @(posedge clk); exp_flags = exp_flags & ~mask;
    @(negedge clk); irq_clr = '0;
    repeat (3) @(negedge clk);
    phase_tag = "-";
  endtask

  task automatic stray_start(input int delay);
    repeat (delay) @(negedge clk);
    phase_tag = "R9";
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    phase_tag = "-";
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);   // reset state compared every cycle (R1, R2, R3)
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Response in third try, card not busy (R3, R4, R5, R7)
    clk_div = 8'd1; busy_limit = 8'd16;
    card_q = '{8'hFF, 8'hFF, 8'h00};
    run_cmd(6'd17, 32'h1234_5678, 7'h2A);
    repeat (5) @(negedge clk);
    clear_flags(5'b00011);
    clear_flags(5'b11100);

    // Immediate response, three busy bytes, stray starts ignored (R7, R9)
    clk_div = 8'd0;
    card_q = '{8'h05, 8'h00, 8'h00, 8'h00};
    fork
      run_cmd(6'd24, 32'hA5A5_0F0F, 7'h7F);
      stray_start(40);
      stray_start(150);
    join
    repeat (5) @(negedge clk);
    clear_flags(5'b11111);

    // No response: timeout (R6)
    clk_div = 8'd2;
    card_q = {};
    run_cmd(6'd63, 32'hFFFF_FFFF, 7'h00);
    repeat (5) @(negedge clk);
    clear_flags(5'b11111);

    // Busy never ends within limit (R8)
    clk_div = 8'd0; busy_limit = 8'd3;
    card_q = '{8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    run_cmd(6'd38, 32'h0000_0001, 7'h55);
    repeat (5) @(negedge clk);
    clear_flags(5'b11111);

    // Response in the last allowed byte (R6 boundary)
    clk_div = 8'd3; busy_limit = 8'd16;
    card_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h7E};
    run_cmd(6'd0, 32'h8000_0000, 7'h4B);
    repeat (5) @(negedge clk);
    clear_flags(5'b11111);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule